// File: doc/BRIEF.md
# Flash Self-Programming Control Register

This block is a CPU-side control register that arms one flash self-programming action at a time. Software writes an enable bit, alone or with one operation-select bit. The block then opens a short acceptance window. During that window it watches the store-to-program-memory or load-from-program-memory instruction strobe from the CPU. When the matching strobe arrives, it sends one command to the flash controller. That command is a temporary-buffer fill, a page erase, a page write or a lock/fuse read.

The armed bits clear by themselves when the window runs out or when the action completes. For a page erase or page write, the enable bit and the operation bit stay set until the controller's busy line falls. The CPU is stalled for that whole time. A ready interrupt request is raised when interrupts are enabled and nothing is pending. A separate watchdog change-enable bit is also held here, and it clears itself a fixed number of cycles after it is set.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset the register reads 0x00. The read layout is: bit 0 enable, bit 1 erase, bit 2 write, bit 3 lock read, bit 4 watchdog change enable, bit 7 interrupt enable. Bits 6:5 always read 0, even when written with 1.
- R2: Writing 0x01 arms a fill. A store strobe sampled on one of the next ARM_WIN clock edges makes `fc_cmd_valid` high for one cycle, starting the cycle after that edge. The command carries op 0, address = Z with bit 0 cleared, and data = `r_pair`. The enable bit reads 0 from that same cycle.
- R3: Writing 0x03 (erase) or 0x05 (write) arms a page operation. A store strobe within ARM_WIN edges issues op 1 (erase) or op 2 (write). Its address is Z with the low PAGE_W bits cleared, and its data is 0.
- R4: If no store strobe is sampled on the ARM_WIN edges after the write, the enable bit and the operation bit read 0 from the next cycle on. A later strobe issues nothing.
- R5: During a page erase or page write, the enable bit and the operation bit stay set. They clear in the cycle after `fc_busy` is first sampled low following a high.
- R6: `cpu_stall` rises together with the erase or write command. It falls together with the clearing in R5. A fill never stalls.
- R7: Writing 0x09 arms a lock read. A load strobe within LOCK_WIN edges issues op 3 with address = Z and data 0. Bits 3 and 0 clear on issue, or after LOCK_WIN edges with no load strobe.
- R8: `ready_irq` is high exactly when bit 7 is set, `gie` is high and bit 0 is clear.
- R9: Writing bit 4 as 1 sets it. It reads 0 again WDCE_CYC cycles after the write edge.
- R10: A write that sets operation bits without the enable bit, or sets more than one operation bit, arms nothing. Bits 3:0 read 0 and a following strobe issues nothing.
- R11: Register writes made while `cpu_stall` is high have no effect on any bit.
- R12: A load strobe while a store action is armed, or a store strobe while a lock read is armed, issues nothing and leaves the armed bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| spm_strobe | input | 1 | Store-to-program-memory instruction strobe |
| lpm_strobe | input | 1 | Load-from-program-memory instruction strobe |
| z_addr | input | ADDR_W | Z pointer value |
| r_pair | input | DATA_W | Register pair data word |
| gie | input | 1 | Global interrupt flag |
| fc_cmd_valid | output | 1 | One-cycle command strobe to the flash controller |
| fc_cmd_op | output | 2 | Command code: 0 fill, 1 erase, 2 write, 3 lock read |
| fc_cmd_addr | output | ADDR_W | Command address |
| fc_cmd_wdata | output | DATA_W | Command data word |
| fc_busy | input | 1 | Flash controller busy |
| cpu_stall | output | 1 | CPU stall request |
| ready_irq | output | 1 | Ready interrupt request |

## Verification
The bench builds the block with ADDR_W 16, PAGE_W 6, ARM_WIN 4, LOCK_WIN 3 and WDCE_CYC 4. With these values the last accepted edge and the first rejected edge of each window are only a handful of cycles apart, so both can be driven directly. The 6-bit page offset means a Z value with mixed low bits shows at once whether the page address and the word address are masked correctly. Busy periods of a few cycles are enough to exercise both the stall and the rule that writes are ignored while busy.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

  typedef enum logic [1:0] {
    FOP_FILL   = 2'd0,
    FOP_ERASE  = 2'd1,
    FOP_WRITE  = 2'd2,
    FOP_LOCKRD = 2'd3
  } flash_op_e;

  // low nibble of the register, packed in bit order 3..0
  typedef struct packed {
    logic lck;
    logic wrt;
    logic ers;
    logic en;
  } arm_t;

  localparam int BIT_WDC = 4;
  localparam int BIT_IE  = 7;

  // only the enable alone or the enable plus exactly one selector arms anything
  function automatic arm_t decode_arm(input logic [3:0] f);
    arm_t a;
    a = '0;
    case (f)
      4'b0001: a.en = 1'b1;
      4'b0011: begin a.en = 1'b1; a.ers = 1'b1; end
      4'b0101: begin a.en = 1'b1; a.wrt = 1'b1; end
      4'b1001: begin a.en = 1'b1; a.lck = 1'b1; end
      default: a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/sp_window_timer.sv
module sp_window_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          cancel,
  output logic          expire
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (load) begin
      act_d = 1'b1;
      cnt_d = load_val;
    end else if (cancel) begin
      act_d = 1'b0;
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  // last edge on which the armed event is still accepted
  assign expire = act_q & (cnt_q == '0);

endmodule

// File: rtl/sp_cmd_fmt.sv
module sp_cmd_fmt
  import selfprog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 6,
  parameter int DATA_W = 16
) (
  input  flash_op_e           op,
  input  logic [ADDR_W-1:0]   z,
  input  logic [DATA_W-1:0]   rdat,
  output logic [ADDR_W-1:0]   addr,
  output logic [DATA_W-1:0]   wdata
);

  always_comb begin
    addr  = z;
    wdata = '0;
    case (op)
      FOP_FILL: begin
        addr  = {z[ADDR_W-1:1], 1'b0};
        wdata = rdat;
      end
      FOP_ERASE, FOP_WRITE: begin
        addr = {z[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
      end
      default: begin
        addr = z;
      end
    endcase
  end

endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
  import selfprog_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 6,
  parameter int DATA_W     = 16,
  parameter int ARM_WIN    = 4,
  parameter int LOCK_WIN   = 3,
  parameter int WDCE_CYC   = 4,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              spm_strobe,
  input  logic              lpm_strobe,
  input  logic [ADDR_W-1:0] z_addr,
  input  logic [DATA_W-1:0] r_pair,
  input  logic              gie,
  output logic              fc_cmd_valid,
  output logic [1:0]        fc_cmd_op,
  output logic [ADDR_W-1:0] fc_cmd_addr,
  output logic [DATA_W-1:0] fc_cmd_wdata,
  input  logic              fc_busy,
  output logic              cpu_stall,
  output logic              ready_irq
);

  localparam int WIN_MAX = (ARM_WIN > LOCK_WIN) ? ARM_WIN : LOCK_WIN;
  localparam int CW      = (WIN_MAX > 1) ? $clog2(WIN_MAX) : 1;
  localparam int WCW     = (WDCE_CYC > 1) ? $clog2(WDCE_CYC) : 1;

  // reset: asserted asynchronously, released through a flop chain
  logic [RST_STAGES-1:0] rs_q;
  logic                  rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rs_q[RST_STAGES-1];

  // state
  arm_t              arm_q, arm_d;
  logic              wdc_q, wdc_d;
  logic              ie_q, ie_d;
  logic              run_q, run_d;
  logic              busy_q;
  logic              cmd_vld_q, cmd_vld_d;
  flash_op_e         cmd_op_q, cmd_op_d;
  logic [ADDR_W-1:0] cmd_addr_q;
  logic [DATA_W-1:0] cmd_data_q;

  // decode
  arm_t              dec;
  logic              sw_wr, busy_fall;
  logic              fire_spm, fire_lpm, fire;
  flash_op_e         fire_op;
  logic              win_load, win_cancel, win_expire;
  logic [CW-1:0]     win_val;
  logic              wdc_load, wdc_expire;
  logic [ADDR_W-1:0] fmt_addr;
  logic [DATA_W-1:0] fmt_data;

  assign dec       = decode_arm(reg_wdata[3:0]);
  assign sw_wr     = reg_wr & ~run_q;
  assign busy_fall = run_q & busy_q & ~fc_busy;
  assign fire_spm  = arm_q.en & ~arm_q.lck & ~run_q & spm_strobe & ~sw_wr;
  assign fire_lpm  = arm_q.en &  arm_q.lck & ~run_q & lpm_strobe & ~sw_wr;
  assign fire      = fire_spm | fire_lpm;

  always_comb begin
    if (arm_q.lck)      fire_op = FOP_LOCKRD;
    else if (arm_q.ers) fire_op = FOP_ERASE;
    else if (arm_q.wrt) fire_op = FOP_WRITE;
    else                fire_op = FOP_FILL;
  end

  assign win_load   = sw_wr & dec.en;
  assign win_val    = dec.lck ? CW'(LOCK_WIN - 1) : CW'(ARM_WIN - 1);
  assign win_cancel = fire | sw_wr;
  assign wdc_load   = sw_wr & reg_wdata[BIT_WDC];

  sp_window_timer #(.CW(CW)) u_arm_win (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (win_load),
    .load_val (win_val),
    .cancel   (win_cancel),
    .expire   (win_expire)
  );

  sp_window_timer #(.CW(WCW)) u_wdc_win (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (wdc_load),
    .load_val (WCW'(WDCE_CYC - 1)),
    .cancel   (sw_wr),
    .expire   (wdc_expire)
  );

  sp_cmd_fmt #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_fmt (
    .op    (fire_op),
    .z     (z_addr),
    .rdat  (r_pair),
    .addr  (fmt_addr),
    .wdata (fmt_data)
  );

  // next state
  always_comb begin
    arm_d     = arm_q;
    ie_d      = ie_q;
    run_d     = run_q;
    cmd_vld_d = fire;
    cmd_op_d  = fire ? fire_op : cmd_op_q;
    if (sw_wr) begin
      arm_d = dec;
      ie_d  = reg_wdata[BIT_IE];
    end else if (run_q) begin
      if (busy_fall) begin
        arm_d = '0;
        run_d = 1'b0;
      end
    end else if (fire) begin
      if (fire_op == FOP_ERASE || fire_op == FOP_WRITE) run_d = 1'b1;
      else                                              arm_d = '0;
    end else if (win_expire && arm_q.en) begin
      arm_d = '0;
    end
  end

  always_comb begin
    wdc_d = wdc_q;
    if (sw_wr)           wdc_d = reg_wdata[BIT_WDC];
    else if (wdc_expire) wdc_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      arm_q     <= '0;
      wdc_q     <= 1'b0;
      ie_q      <= 1'b0;
      run_q     <= 1'b0;
      busy_q    <= 1'b0;
      cmd_vld_q <= 1'b0;
      cmd_op_q  <= FOP_FILL;
    end else begin
      arm_q     <= arm_d;
      wdc_q     <= wdc_d;
      ie_q      <= ie_d;
      run_q     <= run_d;
      busy_q    <= fc_busy;
      cmd_vld_q <= cmd_vld_d;
      cmd_op_q  <= cmd_op_d;
    end
  end

  // command payload, loaded only when a command fires
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      cmd_addr_q <= '0;
      cmd_data_q <= '0;
    end else if (fire) begin
      cmd_addr_q <= fmt_addr;
      cmd_data_q <= fmt_data;
    end
  end

  assign reg_rdata    = {ie_q, 2'b00, wdc_q, arm_q.lck, arm_q.wrt, arm_q.ers, arm_q.en};
  assign fc_cmd_valid = cmd_vld_q;
  assign fc_cmd_op    = cmd_op_q;
  assign fc_cmd_addr  = cmd_addr_q;
  assign fc_cmd_wdata = cmd_data_q;
  assign cpu_stall    = run_q;
  assign ready_irq    = ie_q & gie & ~arm_q.en;

endmodule

// File: rtl/selfprog_ctrl_chk.sv
module selfprog_ctrl_chk #(
  parameter int WDCE_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_rdata,
  input logic       gie,
  input logic       fc_cmd_valid,
  input logic [1:0] fc_cmd_op,
  input logic       cpu_stall,
  input logic       ready_irq
);

  localparam int WC = $clog2(WDCE_CYC + 2) + 1;
  logic [WC-1:0] wdc_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     wdc_run <= '0;
    else if (reg_wr && !cpu_stall)  wdc_run <= '0;
    else if (reg_rdata[4])          wdc_run <= wdc_run + 1'b1;
    else                            wdc_run <= '0;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6:5] == 2'b00);  // R1

  AST_SINGLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(reg_rdata[3:1]) <= 1);  // R10

  AST_OP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[3:1] != 3'b000) |-> reg_rdata[0]);  // R10

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fc_cmd_valid |=> !fc_cmd_valid);  // R2

  AST_FILL_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_cmd_valid && fc_cmd_op == 2'd0) |-> !cpu_stall);  // R2

  AST_STALL_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> (fc_cmd_valid && (fc_cmd_op == 2'd1 || fc_cmd_op == 2'd2)));  // R6

  AST_EN_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> (reg_rdata[0] && (reg_rdata[1] || reg_rdata[2])));  // R5

  AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    ready_irq |-> (gie && reg_rdata[7] && !reg_rdata[0]));  // R8

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall && reg_wr) |=> $stable(reg_rdata[7]));  // R11

  AST_WDCE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    wdc_run <= WC'(WDCE_CYC));  // R9

endmodule

bind selfprog_ctrl selfprog_ctrl_chk #(.WDCE_CYC(WDCE_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_rdata    (reg_rdata),
  .gie          (gie),
  .fc_cmd_valid (fc_cmd_valid),
  .fc_cmd_op    (fc_cmd_op),
  .cpu_stall    (cpu_stall),
  .ready_irq    (ready_irq)
);

// File: tb/selfprog_ctrl_test.sv
`timescale 1ns/1ps
module selfprog_ctrl_test;

  localparam int ADDR_W = 16;
  localparam int PAGE_W = 6;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr;
  logic [7:0]        reg_wdata;
  logic [7:0]        reg_rdata;
  logic              spm_strobe, lpm_strobe;
  logic [ADDR_W-1:0] z_addr;
  logic [DATA_W-1:0] r_pair;
  logic              gie;
  logic              fc_cmd_valid;
  logic [1:0]        fc_cmd_op;
  logic [ADDR_W-1:0] fc_cmd_addr;
  logic [DATA_W-1:0] fc_cmd_wdata;
  logic              fc_busy;
  logic              cpu_stall;
  logic              ready_irq;

  always #4 clk = ~clk;

  selfprog_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
    .ARM_WIN(4), .LOCK_WIN(3), .WDCE_CYC(4)
  ) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .spm_strobe(spm_strobe), .lpm_strobe(lpm_strobe),
    .z_addr(z_addr), .r_pair(r_pair), .gie(gie), .fc_cmd_valid(fc_cmd_valid),
    .fc_cmd_op(fc_cmd_op), .fc_cmd_addr(fc_cmd_addr), .fc_cmd_wdata(fc_cmd_wdata),
    .fc_busy(fc_busy), .cpu_stall(cpu_stall), .ready_irq(ready_irq)
  );

  typedef struct packed {
    logic [1:0]        op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  cmd_t  exp_q[$];
  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R0";
  bit    done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: every issued command must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && fc_cmd_valid) begin
      vectors++;
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL %s unexpected command actual=%h expected=none",
                 cur_req, {fc_cmd_op, fc_cmd_addr, fc_cmd_wdata});
      end else begin
        cmd_t e;
        e = exp_q.pop_front();
        if ({fc_cmd_op, fc_cmd_addr, fc_cmd_wdata} !== e) begin
          miscompares++;
          $display("FAIL %s command actual=%h expected=%h",
                   cur_req, {fc_cmd_op, fc_cmd_addr, fc_cmd_wdata}, e);
        end
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic spm_pulse();
    spm_strobe = 1'b1; tick(); spm_strobe = 1'b0;
  endtask

  task automatic lpm_pulse();
    lpm_strobe = 1'b1; tick(); lpm_strobe = 1'b0;
  endtask

  // driver: push the expected command, then strobe
  task automatic expect_cmd(logic [1:0] op, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    cmd_t c;
    c.op = op; c.addr = a; c.data = d;
    exp_q.push_back(c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; spm_strobe = 1'b0;
    lpm_strobe = 1'b0; z_addr = '0; r_pair = '0; gie = 1'b0; fc_busy = 1'b0;
    tick(4);
    chk("R1 rdata in reset", reg_rdata, 8'h00);
    rst_n = 1'b1;
    tick(4);
    chk("R1 rdata after reset", reg_rdata, 8'h00);
    chk("R1 stall after reset", cpu_stall, 0);
    chk("R8 irq after reset", ready_irq, 0);

    // R2 fill on first accepted edge
    cur_req = "R2";
    z_addr = 16'h1235; r_pair = 16'hBEEF;
    wr(8'h01);
    chk("R2 armed", reg_rdata, 8'h01);
    expect_cmd(2'd0, 16'h1234, 16'hBEEF);
    spm_pulse();
    chk("R2 enable cleared", reg_rdata, 8'h00);
    chk("R6 no stall on fill", cpu_stall, 0);

    // R2 fill on the last accepted edge
    z_addr = 16'h0F0F; r_pair = 16'h1357;
    wr(8'h01);
    tick(3);
    chk("R4 still armed before last edge", reg_rdata, 8'h01);
    expect_cmd(2'd0, 16'h0F0E, 16'h1357);
    spm_pulse();
    chk("R2 cleared after last-edge fill", reg_rdata, 8'h00);

    // R4 timeout
    cur_req = "R4";
    wr(8'h01);
    tick(3);
    chk("R4 armed at fourth cycle", reg_rdata, 8'h01);
    tick();
    chk("R4 cleared after window", reg_rdata, 8'h00);
    spm_pulse();
    tick();
    chk("R4 no command after window", exp_q.size(), 0);
    wr(8'h03);
    tick(4);
    chk("R4 erase disarmed after window", reg_rdata, 8'h00);

    // R3 erase with busy, R5 R6 R11
    cur_req = "R3";
    z_addr = 16'h12F7;
    wr(8'h03);
    tick();
    expect_cmd(2'd1, 16'h12C0, 16'h0000);
    spm_pulse();
    chk("R6 stall with erase command", cpu_stall, 1);
    chk("R5 bits held at start", reg_rdata, 8'h03);
    fc_busy = 1'b1;
    tick();
    chk("R6 stall during busy", cpu_stall, 1);
    wr(8'h91);
    chk("R11 write ignored while busy", reg_rdata, 8'h03);
    tick();
    chk("R5 bits held during busy", reg_rdata, 8'h03);
    fc_busy = 1'b0;
    tick();
    chk("R6 stall released", cpu_stall, 0);
    chk("R5 bits cleared after busy", reg_rdata, 8'h00);

    // R3 page write with irq, R8
    cur_req = "R8";
    gie = 1'b1;
    wr(8'h80);
    chk("R8 irq when idle and enabled", ready_irq, 1);
    wr(8'h85);
    chk("R8 irq low while armed", ready_irq, 0);
    z_addr = 16'hABCD;
    expect_cmd(2'd2, 16'hABC0, 16'h0000);
    cur_req = "R3";
    spm_pulse();
    chk("R6 stall with write command", cpu_stall, 1);
    fc_busy = 1'b1;
    tick(2);
    chk("R5 write bits held", reg_rdata, 8'h85);
    fc_busy = 1'b0;
    tick();
    chk("R5 write bits cleared", reg_rdata, 8'h80);
    chk("R8 irq after completion", ready_irq, 1);
    gie = 1'b0;
    tick();
    chk("R8 irq masked by gie", ready_irq, 0);
    wr(8'h00);

    // R7 lock read on last accepted edge
    cur_req = "R7";
    z_addr = 16'h0003;
    wr(8'h09);
    tick(2);
    expect_cmd(2'd3, 16'h0003, 16'h0000);
    lpm_pulse();
    chk("R7 cleared after lock read", reg_rdata, 8'h00);
    wr(8'h09);
    tick(2);
    chk("R7 armed on third cycle", reg_rdata, 8'h09);
    tick();
    chk("R7 cleared after lock window", reg_rdata, 8'h00);

    // R12 wrong strobe kinds
    cur_req = "R12";
    wr(8'h09);
    spm_pulse();
    chk("R12 store strobe ignored by lock read", reg_rdata, 8'h09);
    wr(8'h01);
    lpm_pulse();
    chk("R12 load strobe ignored by fill", reg_rdata, 8'h01);
    wr(8'h00);
    tick();
    chk("R12 no command issued", exp_q.size(), 0);

    // R10 illegal combinations, R1 reserved bits
    cur_req = "R10";
    wr(8'h02);
    chk("R10 erase without enable", reg_rdata, 8'h00);
    wr(8'h07);
    chk("R10 two operation bits", reg_rdata, 8'h00);
    spm_pulse();
    tick();
    chk("R10 nothing issued", exp_q.size(), 0);
    wr(8'h60);
    chk("R1 reserved bits read zero", reg_rdata, 8'h00);

    // R9 watchdog change enable
    cur_req = "R9";
    wr(8'h10);
    chk("R9 set", reg_rdata, 8'h10);
    tick(3);
    chk("R9 still set at fourth cycle", reg_rdata, 8'h10);
    tick();
    chk("R9 cleared by hardware", reg_rdata, 8'h00);

    tick(2);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule